// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This bridge lets a host register bus reach a small byte-wide PHY register file that has no direct mapping. The host exposes two words: a data word and a command word. Software first puts the byte to send into the data word. It then writes the command word, which holds the PHY offset and a direction bit. That command write starts one transaction on the PHY side.

While the transaction runs, a busy bit in the command word stays high. Software polls that bit. When it falls, a read has left the fetched byte in the data word, and a write has delivered the data byte to the PHY.

The PHY side is a plain level request with an acknowledge. The bridge holds the request, offset, direction and write byte steady until the PHY answers. A command written while a transaction is in flight is dropped, and a sticky error bit records that it was dropped.

Top module: `phy_ind_bridge`

## Requirements
- R1: The command word is decoded at host offset 0x300 and the data word at host offset 0x304. Any other offset reads as zero and is not affected by host writes.
- R2: Command word layout: bits 7:0 hold the PHY offset and bit 8 is the direction, with 1 meaning write and 0 meaning read. Reading the command word returns bits 8:0 of the last accepted command.
- R3: Bit 9 of the command word is busy. It reads 1 starting on the clock edge that samples an accepted command write. phy_req_o equals busy. While busy, phy_addr_o, phy_we_o and phy_wdata_o do not change.
- R4: Busy and phy_req_o fall on the clock edge that samples phy_ack_i high while busy. They are therefore low in the cycle after the acknowledge.
- R5: A write transaction presents phy_we_o=1 and phy_wdata_o equal to bits 7:0 of the data word, so the addressed PHY register receives that byte.
- R6: A read transaction presents phy_we_o=0. On completion, bits 7:0 of the data word take phy_rdata_i as sampled with the acknowledge.
- R7: Only bits 7:0 of the data word are stored. Host write bits above bit 7 are discarded, and bits 31:8 always read as zero.
- R8: A command write that arrives while busy is ignored and does not change the PHY-side outputs. It sets the error bit, which is bit 10 of the command word.
- R9: The error bit is cleared by the next command write that is accepted while idle.
- R10: A host write to the data word while busy is ignored.
- R11: phy_ack_i while idle has no effect on busy or on the data word.
- R12: After reset, busy, error, the last command and the data word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe, one cycle per write |
| host_addr_i | input | 12 | Host register offset for both reads and writes |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data for host_addr_i, combinational |
| phy_req_o | output | 1 | Transaction request, held until acknowledged |
| phy_we_o | output | 1 | 1 for a PHY write, 0 for a PHY read |
| phy_addr_o | output | 8 | PHY register offset |
| phy_wdata_o | output | 8 | PHY write byte |
| phy_rdata_i | input | 8 | PHY read byte, valid with phy_ack_i |
| phy_ack_i | input | 1 | PHY acknowledge, one cycle |

## Verification
The assertions rely on three assumptions about the PHY. It acknowledges only while phy_req_o is high, pulses phy_ack_i for one cycle per request, and has phy_rdata_i valid in the acknowledge cycle. There is one exception: the idle-acknowledge property covers a stray acknowledge on purpose.

The bench's PHY model honours these assumptions and varies its acknowledge delay from zero to three cycles. A separate stray acknowledge is injected only while the bridge is idle. Host writes are one-cycle strobes driven between clock edges, and rejected commands are issued only while a transaction is known to be in flight.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/phy_bridge_ctrl.sv
module phy_bridge_ctrl #(
  parameter int PHY_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic              cmd_we_i,
  input  logic [PHY_AW-1:0] cmd_addr_i,
  input  logic              phy_ack_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              cmd_we_o,
  output logic [PHY_AW-1:0] cmd_addr_o,
  output logic              done_o
);
  logic              busy_q, err_q, we_q;
  logic [PHY_AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      if (busy_q && phy_ack_i) busy_q <= 1'b0;
      if (cmd_wr_i) begin
        if (busy_q) begin
          err_q <= 1'b1;
        end else begin
          err_q  <= 1'b0;
          busy_q <= 1'b1;
          we_q   <= cmd_we_i;
          addr_q <= cmd_addr_i;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign err_o      = err_q;
  assign cmd_we_o   = we_q;
  assign cmd_addr_o = addr_q;
  assign done_o     = busy_q & phy_ack_i;
endmodule

// File: rtl/phy_bridge_data.sv
module phy_bridge_data #(
  parameter int PHY_DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PHY_DW-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [PHY_DW-1:0] load_data_i,
  output logic [PHY_DW-1:0] data_o
);
  logic [PHY_DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             data_q <= '0;
    else if (load_i)         data_q <= load_data_i;
    else if (wr_i && !busy_i) data_q <= wdata_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/phy_ind_bridge.sv
module phy_ind_bridge
  import phy_bridge_pkg::*;
#(
  parameter int                 HOST_AW  = 12,
  parameter int                 HOST_DW  = 32,
  parameter int                 PHY_AW   = 8,
  parameter int                 PHY_DW   = 8,
  parameter logic [HOST_AW-1:0] CMD_OFF  = 12'h300,
  parameter logic [HOST_AW-1:0] DATA_OFF = 12'h304
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_wr_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [HOST_DW-1:0] host_wdata_i,
  output logic [HOST_DW-1:0] host_rdata_o,
  output logic               phy_req_o,
  output logic               phy_we_o,
  output logic [PHY_AW-1:0]  phy_addr_o,
  output logic [PHY_DW-1:0]  phy_wdata_o,
  input  logic [PHY_DW-1:0]  phy_rdata_i,
  input  logic               phy_ack_i
);
  localparam int WE_BIT   = PHY_AW;
  localparam int BUSY_BIT = PHY_AW + 1;
  localparam int ERR_BIT  = PHY_AW + 2;

  reg_sel_e          sel;
  logic              busy, err, cmd_we, done;
  logic [PHY_AW-1:0] cmd_addr;
  logic [PHY_DW-1:0] data_q;
  logic              unused_wdata;

  always_comb begin
    if (host_addr_i == CMD_OFF)       sel = SEL_CMD;
    else if (host_addr_i == DATA_OFF) sel = SEL_DATA;
    else                              sel = SEL_NONE;
  end

  phy_bridge_ctrl #(.PHY_AW(PHY_AW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (host_wr_i && sel == SEL_CMD),
    .cmd_we_i   (host_wdata_i[WE_BIT]),
    .cmd_addr_i (host_wdata_i[PHY_AW-1:0]),
    .phy_ack_i  (phy_ack_i),
    .busy_o     (busy),
    .err_o      (err),
    .cmd_we_o   (cmd_we),
    .cmd_addr_o (cmd_addr),
    .done_o     (done)
  );

  phy_bridge_data #(.PHY_DW(PHY_DW)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (host_wr_i && sel == SEL_DATA),
    .wdata_i     (host_wdata_i[PHY_DW-1:0]),
    .busy_i      (busy),
    .load_i      (done && !cmd_we),
    .load_data_i (phy_rdata_i),
    .data_o      (data_q)
  );

  always_comb begin
    host_rdata_o = '0;
    unique case (sel)
      SEL_CMD: begin
        host_rdata_o[PHY_AW-1:0] = cmd_addr;
        host_rdata_o[WE_BIT]     = cmd_we;
        host_rdata_o[BUSY_BIT]   = busy;
        host_rdata_o[ERR_BIT]    = err;
      end
      SEL_DATA: host_rdata_o[PHY_DW-1:0] = data_q;
      default:  host_rdata_o = '0;
    endcase
  end

  assign phy_req_o    = busy;
  assign phy_we_o     = cmd_we;
  assign phy_addr_o   = cmd_addr;
  assign phy_wdata_o  = data_q;
  assign unused_wdata = ^host_wdata_i;
endmodule

// File: rtl/phy_ind_bridge_chk.sv
module phy_ind_bridge_chk #(
  parameter int                 HOST_AW  = 12,
  parameter int                 HOST_DW  = 32,
  parameter int                 PHY_AW   = 8,
  parameter int                 PHY_DW   = 8,
  parameter logic [HOST_AW-1:0] CMD_OFF  = 12'h300,
  parameter logic [HOST_AW-1:0] DATA_OFF = 12'h304
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               host_wr_i,
  input logic [HOST_AW-1:0] host_addr_i,
  input logic [HOST_DW-1:0] host_wdata_i,
  input logic [HOST_DW-1:0] host_rdata_o,
  input logic               phy_req_o,
  input logic               phy_we_o,
  input logic [PHY_AW-1:0]  phy_addr_o,
  input logic [PHY_DW-1:0]  phy_wdata_o,
  input logic [PHY_DW-1:0]  phy_rdata_i,
  input logic               phy_ack_i
);
  logic cmd_wr;
  assign cmd_wr = host_wr_i && host_addr_i == CMD_OFF;

  p_launch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && !phy_req_o |=> phy_req_o && phy_addr_o == $past(host_wdata_i[PHY_AW-1:0])
                             && phy_we_o == $past(host_wdata_i[PHY_AW]));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_ack_i |=> phy_req_o && $stable(phy_addr_o) && $stable(phy_we_o)
                                && $stable(phy_wdata_o));

  p_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && phy_ack_i |=> !phy_req_o);

  p_read_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_addr_i == DATA_OFF && $past(phy_req_o && phy_ack_i && !phy_we_o)
      |-> host_rdata_o[PHY_DW-1:0] == $past(phy_rdata_i));

  p_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_addr_i == DATA_OFF |-> host_rdata_o[HOST_DW-1:PHY_DW] == '0);

  p_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && phy_req_o |=> $stable(phy_addr_o) && $stable(phy_we_o));

  p_idle_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_req_o && !cmd_wr |=> !phy_req_o);

  p_other_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_addr_i != CMD_OFF && host_addr_i != DATA_OFF |-> host_rdata_o == '0);

  logic unused_chk;
  assign unused_chk = ^{host_wdata_i, phy_rdata_i};
endmodule

bind phy_ind_bridge phy_ind_bridge_chk #(
  .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW),
  .CMD_OFF(CMD_OFF), .DATA_OFF(DATA_OFF)
) i_chk (.*);

// File: tb/test_phy_ind_bridge.sv
module test_phy_ind_bridge;
  localparam logic [11:0] CMD  = 12'h300;
  localparam logic [11:0] DATA = 12'h304;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        phy_req, phy_we;
  logic [7:0]  phy_addr, phy_wdata, m_rdata;
  logic        m_ack, ext_ack = 1'b0;
  logic [7:0]  mem [256];
  int          dly = 0, cnt = 0;
  int          n_tests = 0, n_fail = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  phy_ind_bridge i_phy_ind_bridge (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .phy_req_o(phy_req),
    .phy_we_o(phy_we), .phy_addr_o(phy_addr), .phy_wdata_o(phy_wdata),
    .phy_rdata_i(ext_ack ? 8'hEE : m_rdata), .phy_ack_i(m_ack | ext_ack)
  );

  // PHY model: acknowledges dly cycles after it sees the request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack <= 1'b0; m_rdata <= '0; cnt <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (phy_req && !m_ack) begin
      if (cnt >= dly) begin
        m_ack <= 1'b1; cnt <= 0;
        if (phy_we) mem[phy_addr] <= phy_wdata;
        else        m_rdata <= mem[phy_addr];
      end else cnt <= cnt + 1;
    end else m_ack <= 1'b0;
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(logic [11:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int k = 0;
    hrd(CMD, v);
    while (v[9] && k < 50) begin
      @(negedge clk); hrd(CMD, v); k++;
    end
  endtask

  // R3/R4 handshake monitor
  logic prev_req = 1'b0, prev_ack = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req && prev_ack) chk("R4 req drops after ack", 32'(phy_req), 32'd0);
      else if (prev_req)        chk("R3 req held until ack", 32'(phy_req), 32'd1);
    end
    prev_req <= phy_req;
    prev_ack <= m_ack | ext_ack;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    hrd(CMD, rv);  chk("R12 cmd reset", rv, 32'h0);
    hrd(DATA, rv); chk("R12 data reset", rv, 32'h0);
    chk("R12 req reset", 32'(phy_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    hwr(12'h308, 32'hFFFF_FFFF);
    hrd(12'h308, rv); chk("R1 other offset", rv, 32'h0);
    hrd(DATA, rv);    chk("R1 other offset no effect", rv, 32'h0);

    // write sweep across all PHY offsets
    for (int a = 0; a < 256; a++) begin
      dly = a % 4;
      hwr(DATA, 32'(pat(a)));
      hwr(CMD, 32'h100 | 32'(a));
      hrd(CMD, rv); chk("R3 busy after cmd", rv & 32'h200, 32'h200);
      wait_idle();
      chk("R5 phy write", 32'(mem[a]), 32'(pat(a)));
    end
    // read sweep
    for (int a = 0; a < 256; a++) begin
      dly = (a + 1) % 4;
      hwr(CMD, 32'(a));
      wait_idle();
      hrd(DATA, rv); chk("R6 read data", rv, 32'(pat(a)));
      hrd(CMD, rv);  chk("R2 cmd readback", rv, 32'(a));
    end

    hwr(DATA, 32'hABCD_1234);
    hrd(DATA, rv); chk("R7 upper bits", rv, 32'h34);

    // rejected command and data write while busy
    dly = 3;
    hwr(DATA, 32'h5A);
    hwr(CMD, 32'h110);
    hwr(CMD, 32'h120);
    hwr(DATA, 32'hC3);
    hrd(CMD, rv); chk("R8 err set, cmd kept", rv, 32'h710);
    wait_idle();
    chk("R8 first cmd done", 32'(mem[8'h10]), 32'h5A);
    chk("R8 second cmd dropped", 32'(mem[8'h20]), 32'(pat(8'h20)));
    hrd(CMD, rv);  chk("R8 err sticky", rv, 32'h510);
    hrd(DATA, rv); chk("R10 data write ignored", rv, 32'h5A);

    dly = 0;
    hwr(CMD, 32'h010);
    hrd(CMD, rv); chk("R9 err cleared", rv, 32'h210);
    wait_idle();
    hrd(DATA, rv); chk("R6 read back 5A", rv, 32'h5A);

    // stray ack while idle
    @(negedge clk); ext_ack = 1'b1;
    @(negedge clk); ext_ack = 1'b0;
    @(negedge clk);
    hrd(DATA, rv); chk("R11 idle ack data", rv, 32'h5A);
    hrd(CMD, rv);  chk("R11 idle ack busy", rv, 32'h010);

    rst_n = 1'b0;
    @(negedge clk);
    hrd(CMD, rv);  chk("R12 cmd after reset", rv, 32'h0);
    hrd(DATA, rv); chk("R12 data after reset", rv, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule